// File: doc/BRIEF.md
# Password-Gated Paged Register Map

This block is a byte-addressed register store behind a simple register bus with an 8-bit address, write data, write strobe, read strobe and registered read data. The lower half of the address space is a flat region that every access sees the same way. The upper half is a window onto one of several 128-byte tables, and a page-select byte in the flat region chooses which table that is.

Access is controlled by three privilege levels: user, level one and level two. A 4-byte entry field in the flat region can be written at any time. Its value is compared against two 4-byte passwords kept inside the protected table. The resulting level decides, for each region, whether a read returns data and whether a write changes storage. A refused read returns 00h and a refused write is dropped. The passwords and the entry field can never be read back. If the level-two password is all ones, the entry field's reset value already matches it, so protection is off.

Top module: `pgreg_map`

## Requirements
- R1: After reset every table byte and flat byte is 00h, the page-select byte is 00h, the entry field is FFFFFFFFh, both passwords are 00000000h, the level is user and rd_data is 00h.
- R2: Bytes 00h–7Ah are readable at any level and writable only at level two, and they return the same contents whatever page is selected.
- R3: Byte 7Fh is the page-select byte. It is readable and writable at any level. Addresses 80h–FFh reach byte (address − 80h) of the table it selects. With a page-select value of 06h or more, reads return 00h and writes change nothing.
- R4: The entry field at 7Bh–7Eh is writable at any level and always reads 00h. Entry byte 7Bh+i is compared with table 03h byte B0h+i for password one and with table 03h byte B4h+i for password two.
- R5: The level is two when the entry equals password two, otherwise one when the entry equals password one, otherwise user. A write that changes the entry or a password governs accesses from the next cycle onward.
- R6: Table 03h bytes B0h–B7h (the passwords) always read 00h, even at level two, and are writable only at level two.
- R7: The other bytes of table 03h are readable and writable only at level two. At lower levels they read 00h.
- R8: Tables 00h and 01h are readable and writable at level one or two. At user level they read 00h and ignore writes.
- R9: Tables 02h, 04h and 05h are readable at any level and writable only at level two.
- R10: When password two is FFFFFFFFh and the entry holds FFFFFFFFh, the level is two.
- R11: rd_data is updated on the clock edge where rd_en is sampled. It shows the contents from before any write in that same cycle, or 00h for a refused read. It holds its value while rd_en is low.
- R12: An accepted write changes storage on the edge where wr_en is sampled, so a read strobe in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |

## Verification
On every cycle, the assertions check that the entry field and the password bytes read back as zero, that a missing table reads zero, and that the protected table is blank at user level. They also check that rd_data holds while no read is strobed, and that the page-select byte and the entry field change only when written. Other behaviour needs the bench's scenarios against its reference model. This covers how the level depends on the stored passwords, including the step-by-step hand-over when password two is changed while it is entered. It also covers refused writes staying invisible to later reads, the read-before-write order in a single cycle, and the all-ones password that turns protection off.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

    localparam int          PAGE_BYTES = 128;
    localparam int          PW_BYTES   = 4;
    localparam int          PW_W       = 8 * PW_BYTES;
    localparam int          DEF_TABLES = 6;

    localparam logic [7:0]  ENTRY_BASE = 8'h7B;
    localparam logic [7:0]  PSEL_ADDR  = 8'h7F;

    localparam logic [7:0]  TBL_CUST0  = 8'h00;
    localparam logic [7:0]  TBL_CUST1  = 8'h01;
    localparam logic [7:0]  TBL_PW     = 8'h03;

    // Offsets inside the protected table where the two passwords live
    localparam logic [6:0]  PW1_OFF    = 7'h30;
    localparam logic [6:0]  PW2_OFF    = PW1_OFF + 7'(PW_BYTES);
    localparam logic [6:0]  PW_END     = PW1_OFF + 7'(2 * PW_BYTES);

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_ONE  = 2'd1,
        LVL_TWO  = 2'd2
    } level_e;

    typedef enum logic [1:0] {
        RG_FLAT,
        RG_ENTRY,
        RG_PSEL,
        RG_PAGE
    } region_e;

    typedef struct packed {
        region_e region;
        logic    rd_ok;
        logic    wr_ok;
    } perm_t;

    function automatic logic is_pw_off(input logic [6:0] off);
        return (off >= PW1_OFF) && (off < PW_END);
    endfunction

    // Per-access permission decision from address, selected page and level
    function automatic perm_t decide(input logic [7:0] a, input logic [7:0] psel,
                                     input level_e lvl, input int unsigned ntab);
        perm_t p;
        logic  top2;
        logic  top1;
        top2     = (lvl == LVL_TWO);
        top1     = (lvl != LVL_USER);
        p.region = RG_PAGE;
        p.rd_ok  = 1'b0;
        p.wr_ok  = 1'b0;
        if (!a[7]) begin
            if (a < ENTRY_BASE) begin
                p.region = RG_FLAT;
                p.rd_ok  = 1'b1;
                p.wr_ok  = top2;
            end else if (a == PSEL_ADDR) begin
                p.region = RG_PSEL;
                p.rd_ok  = 1'b1;
                p.wr_ok  = 1'b1;
            end else begin
                p.region = RG_ENTRY;
                p.wr_ok  = 1'b1;
            end
        end else if ({24'd0, psel} < ntab) begin
            if (psel == TBL_CUST0 || psel == TBL_CUST1) begin
                p.rd_ok = top1;
                p.wr_ok = top1;
            end else if (psel == TBL_PW) begin
                p.rd_ok = top2 && !is_pw_off(a[6:0]);
                p.wr_ok = top2;
            end else begin
                p.rd_ok = 1'b1;
                p.wr_ok = top2;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/pgreg_level.sv
module pgreg_level
    import pgreg_pkg::*;
(
    input  logic [PW_W-1:0] entry,
    input  logic [PW_W-1:0] pw1,
    input  logic [PW_W-1:0] pw2,
    output level_e          level
);
    // Level two has priority when both passwords match the entry
    always_comb begin
        if (entry == pw2)      level = LVL_TWO;
        else if (entry == pw1) level = LVL_ONE;
        else                   level = LVL_USER;
    end
endmodule

// File: rtl/pgreg_perm.sv
module pgreg_perm
    import pgreg_pkg::*;
#(
    parameter int NUM_TABLES = DEF_TABLES
) (
    input  logic [7:0] addr,
    input  logic [7:0] psel,
    input  level_e     level,
    output perm_t      perm
);
    always_comb perm = decide(addr, psel, level, NUM_TABLES);
endmodule

// File: rtl/pgreg_store.sv
module pgreg_store
    import pgreg_pkg::*;
#(
    parameter int NUM_TABLES = DEF_TABLES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_ok_en,
    input  region_e         region,
    input  logic [7:0]      addr,
    input  logic [7:0]      wr_data,
    output logic [7:0]      rd_byte,
    output logic [7:0]      psel,
    output logic [PW_W-1:0] entry,
    output logic [PW_W-1:0] pw1,
    output logic [PW_W-1:0] pw2
);
    localparam int FLAT_BYTES = int'(ENTRY_BASE);
    localparam int TW         = $clog2(NUM_TABLES);
    localparam int EW         = $clog2(PW_BYTES);

    logic [7:0]    flat_q  [FLAT_BYTES];
    logic [7:0]    entry_q [PW_BYTES];
    logic [7:0]    psel_q;
    logic [7:0]    page_rd [NUM_TABLES];
    logic [EW-1:0] eidx;
    logic          psel_valid;

    // Entry byte index: address minus base, modulo the field size
    assign eidx       = addr[EW-1:0] - ENTRY_BASE[EW-1:0];
    assign psel_valid = ({24'd0, psel_q} < NUM_TABLES);
    assign psel       = psel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FLAT_BYTES; i++) flat_q[i] <= '0;
        end else if (wr_ok_en && region == RG_FLAT) begin
            flat_q[addr[6:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PW_BYTES; i++) entry_q[i] <= 8'hFF;
        end else if (wr_ok_en && region == RG_ENTRY) begin
            entry_q[eidx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                   psel_q <= '0;
        else if (wr_ok_en && region == RG_PSEL)    psel_q <= wr_data;
    end

    for (genvar k = 0; k < PW_BYTES; k++) begin : g_entry
        assign entry[8*(PW_BYTES-1-k) +: 8] = entry_q[k];
    end

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
        logic [7:0] page_q [PAGE_BYTES];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < PAGE_BYTES; i++) page_q[i] <= '0;
            end else if (wr_ok_en && region == RG_PAGE && psel_q == 8'(t)) begin
                page_q[addr[6:0]] <= wr_data;
            end
        end

        assign page_rd[t] = page_q[addr[6:0]];

        if (t == int'(TBL_PW)) begin : g_pw
            for (genvar k = 0; k < PW_BYTES; k++) begin : g_pwb
                assign pw1[8*(PW_BYTES-1-k) +: 8] = page_q[int'(PW1_OFF) + k];
                assign pw2[8*(PW_BYTES-1-k) +: 8] = page_q[int'(PW2_OFF) + k];
            end
        end
    end

    always_comb begin
        unique case (region)
            RG_FLAT:  rd_byte = flat_q[addr[6:0]];
            RG_PSEL:  rd_byte = psel_q;
            RG_PAGE:  rd_byte = psel_valid ? page_rd[psel_q[TW-1:0]] : '0;
            default:  rd_byte = '0;
        endcase
    end

    // R3: the page-select byte moves only on an accepted write to it
    p_psel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_ok_en && region == RG_PSEL) |=> $stable(psel_q));

    // R4: the entry field moves only on a write into its four bytes
    p_entry_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_ok_en && region == RG_ENTRY) |=> $stable(entry));

endmodule

// File: rtl/pgreg_map.sv
module pgreg_map
    import pgreg_pkg::*;
#(
    parameter int NUM_TABLES = DEF_TABLES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data
);
    perm_t           perm;
    level_e          level;
    logic [7:0]      psel;
    logic [7:0]      rd_byte;
    logic [PW_W-1:0] entry;
    logic [PW_W-1:0] pw1;
    logic [PW_W-1:0] pw2;
    logic            wr_ok_en;
    logic [7:0]      rd_q;

    pgreg_level u_level (
        .entry (entry),
        .pw1   (pw1),
        .pw2   (pw2),
        .level (level)
    );

    pgreg_perm #(.NUM_TABLES(NUM_TABLES)) u_perm (
        .addr  (addr),
        .psel  (psel),
        .level (level),
        .perm  (perm)
    );

    assign wr_ok_en = wr_en && perm.wr_ok;

    pgreg_store #(.NUM_TABLES(NUM_TABLES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_ok_en (wr_ok_en),
        .region   (perm.region),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_byte  (rd_byte),
        .psel     (psel),
        .entry    (entry),
        .pw1      (pw1),
        .pw2      (pw2)
    );

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= perm.rd_ok ? rd_byte : '0;
    end

    assign rd_data = rd_q;

    // R4: entry bytes never read back
    p_entry_hidden_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr >= ENTRY_BASE && addr < PSEL_ADDR) |=> (rd_data == 8'h00));

    // R6: password bytes read zero at every level
    p_pw_hidden_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[7] && psel == TBL_PW && is_pw_off(addr[6:0])) |=> (rd_data == 8'h00));

    // R3: a missing table reads zero
    p_missing_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[7] && {24'd0, psel} >= NUM_TABLES) |=> (rd_data == 8'h00));

    // R7: the protected table is blank below level two
    p_pwtable_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[7] && psel == TBL_PW && level != LVL_TWO) |=> (rd_data == 8'h00));

    // R11: read data holds without a read strobe
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R10: an all-ones password two with an all-ones entry opens level two
    p_open_r10: assert property (@(posedge clk) disable iff (rst)
        (pw2 == '1 && entry == '1) |-> (level == LVL_TWO));

endmodule

// File: tb/pgreg_map_tb.sv
module pgreg_map_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] m_flat [128];
    logic [7:0] m_tbl  [6][128];
    logic [7:0] m_ent  [4];
    logic [7:0] m_psel;
    logic [7:0] prev_rd;

    always #2 clk = ~clk;

    pgreg_map dut_i (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h exp %02h", tag, got, exp);
        end
    endtask

    function automatic int mlev();
        bit m1 = 1'b1;
        bit m2 = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (m_ent[i] != m_tbl[3][8'h30 + i]) m1 = 1'b0;
            if (m_ent[i] != m_tbl[3][8'h34 + i]) m2 = 1'b0;
        end
        return m2 ? 2 : (m1 ? 1 : 0);
    endfunction

    function automatic bit m_rok(input logic [7:0] a);
        int o = int'(a) - 128;
        if (a < 8'h7B) return 1'b1;
        if (a < 8'h7F) return 1'b0;
        if (a == 8'h7F) return 1'b1;
        if (m_psel > 8'd5) return 1'b0;
        if (m_psel <= 8'd1) return mlev() >= 1;
        if (m_psel == 8'd3) return (o < 8'h30 || o > 8'h37) && mlev() == 2;
        return 1'b1;
    endfunction

    function automatic bit m_wok(input logic [7:0] a);
        if (a < 8'h7B) return mlev() == 2;
        if (a <= 8'h7F) return 1'b1;
        if (m_psel > 8'd5) return 1'b0;
        if (m_psel <= 8'd1) return mlev() >= 1;
        return mlev() == 2;
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a < 8'h7B) return m_flat[a];
        if (a == 8'h7F) return m_psel;
        return m_tbl[m_psel][a - 8'h80];
    endfunction

    task automatic m_write(input logic [7:0] a, input logic [7:0] d);
        if (a < 8'h7B)       m_flat[a] = d;
        else if (a < 8'h7F)  m_ent[a - 8'h7B] = d;
        else if (a == 8'h7F) m_psel = d;
        else                 m_tbl[m_psel][a - 8'h80] = d;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 128; i++) m_flat[i] = '0;
        for (int t = 0; t < 6; t++)
            for (int i = 0; i < 128; i++) m_tbl[t][i] = '0;
        for (int i = 0; i < 4; i++) m_ent[i] = 8'hFF;
        m_psel  = '0;
        prev_rd = '0;
    endtask

    task automatic op(input bit r, input bit w, input logic [7:0] a,
                      input logic [7:0] d, input string tag);
        logic [7:0] exp;
        bit         wok;
        @(negedge clk);
        addr = a; rd_en = r; wr_en = w; wr_data = d;
        exp = (r && m_rok(a)) ? m_read(a) : (r ? 8'h00 : prev_rd);
        wok = m_wok(a);
        @(posedge clk);
        #1;
        rd_en = 1'b0; wr_en = 1'b0;
        if (w && wok) m_write(a, d);
        check(tag, rd_data, exp);
        prev_rd = exp;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        op(1'b0, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        op(1'b1, 1'b0, a, 8'h00, tag);
    endtask

    // Replace password two byte by byte, keeping the entry in step
    task automatic swap_pw2(input logic [31:0] v, input string tag);
        for (int k = 0; k < 4; k++) begin
            wr(8'hB4 + 8'(k), v[8*(3-k) +: 8], tag);
            wr(8'h7B + 8'(k), v[8*(3-k) +: 8], tag);
        end
    endtask

    task automatic enter(input logic [31:0] v, input string tag);
        for (int k = 0; k < 4; k++) wr(8'h7B + 8'(k), v[8*(3-k) +: 8], tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rd_data", rd_data, 8'h00);
        rd(8'h00, "R1 flat");
        rd(8'h7B, "R1 entry");
        rd(8'h7F, "R1 psel");
        wr(8'h7F, 8'h02, "R3 psel write user");
        rd(8'h7F, "R3 psel readback");
        rd(8'h85, "R1 table2 byte");

        // User level refusals
        wr(8'h10, 8'h5A, "R2 user flat write");
        rd(8'h10, "R2 user flat ignored");
        wr(8'h90, 8'h44, "R9 user table2 write");
        rd(8'h90, "R9 user table2 ignored");
        wr(8'h7F, 8'h03, "R3 psel");
        rd(8'hC0, "R7 user pwtable");

        // Entering all zeros matches the reset passwords: level two
        enter(32'h0000_0000, "R5 enter zeros");
        wr(8'h10, 8'h5A, "R2 lvl2 flat write");
        rd(8'h10, "R12 flat readback");
        wr(8'hC0, 8'h77, "R7 lvl2 pwtable write");
        rd(8'hC0, "R7 lvl2 pwtable read");
        for (int k = 0; k < 4; k++) wr(8'hB0 + 8'(k), 8'h11 * 8'(k + 1), "R6 pw1 write");
        swap_pw2(32'hAABB_CCDD, "R5 pw2 hand-over");
        rd(8'hC0, "R5 still level two");
        rd(8'hB0, "R6 pw1 hidden");
        rd(8'hB5, "R6 pw2 hidden");
        wr(8'h7F, 8'h02, "R3 psel");
        wr(8'h90, 8'h44, "R9 lvl2 table2 write");
        rd(8'h90, "R9 table2 readback");

        // Level one
        enter(32'h1122_3344, "R5 enter pw1");
        rd(8'h90, "R9 lvl1 table2 read");
        wr(8'h90, 8'h99, "R9 lvl1 table2 write");
        rd(8'h90, "R9 lvl1 table2 unchanged");
        wr(8'h7F, 8'h00, "R3 psel");
        wr(8'h80, 8'h3C, "R8 lvl1 table0 write");
        rd(8'h80, "R8 lvl1 table0 read");
        wr(8'h7F, 8'h01, "R3 psel");
        wr(8'hFF, 8'hC3, "R8 lvl1 table1 write");
        rd(8'hFF, "R8 lvl1 table1 read");
        wr(8'h10, 8'h01, "R2 lvl1 flat write");
        rd(8'h10, "R2 lvl1 flat unchanged");
        wr(8'h7F, 8'h03, "R3 psel");
        rd(8'hC0, "R7 lvl1 pwtable hidden");
        wr(8'hB0, 8'h99, "R6 lvl1 pw1 write");
        enter(32'h1122_3344, "R6 reenter pw1");
        wr(8'h7F, 8'h00, "R3 psel");
        rd(8'h80, "R6 pw1 kept, lvl1 holds");

        // User again
        wr(8'h7E, 8'h00, "R5 spoil entry");
        rd(8'h80, "R8 user table0 hidden");
        wr(8'h80, 8'h01, "R8 user table0 write");
        wr(8'h7F, 8'h04, "R3 psel");
        rd(8'h80, "R9 user table4 read");

        // Missing tables
        enter(32'hAABB_CCDD, "R5 enter pw2");
        wr(8'h7F, 8'h06, "R3 psel 06");
        wr(8'h80, 8'h5E, "R3 missing write");
        rd(8'h80, "R3 missing read");
        wr(8'h7F, 8'hFF, "R3 psel FF");
        rd(8'hA0, "R3 missing read FF");
        wr(8'h7F, 8'h00, "R3 psel");
        rd(8'h80, "R3 table0 unaliased");

        // Same-cycle read and write
        op(1'b1, 1'b1, 8'h10, 8'hA5, "R11 read before write");
        rd(8'h10, "R12 write visible");
        op(1'b0, 1'b0, 8'h10, 8'h00, "R11 hold");

        // Protection off with all-ones password two
        wr(8'h7F, 8'h03, "R3 psel");
        swap_pw2(32'hFFFF_FFFF, "R10 pw2 ones");
        rd(8'hC0, "R10 open level two");
        rd(8'h7C, "R4 entry hidden");

        // Constrained random phase
        void'($urandom(32'd2718));
        for (int n = 0; n < 4000; n++) begin
            int         sel  = int'($urandom_range(99));
            bit         r    = 1'($urandom_range(1));
            bit         w    = 1'($urandom_range(1));
            logic [7:0] a;
            logic [7:0] d    = 8'($urandom);
            if (sel < 25) begin
                a = 8'($urandom_range(8'h7A));
            end else if (sel < 45) begin
                int k = int'($urandom_range(3));
                int p = int'($urandom_range(2));
                a = 8'h7B + 8'(k);
                if (p == 0)      d = m_tbl[3][8'h30 + k];
                else if (p == 1) d = m_tbl[3][8'h34 + k];
            end else if (sel < 55) begin
                a = 8'h7F;
                d = 8'($urandom_range(7));
            end else begin
                a = 8'h80 | 8'($urandom_range(127));
            end
            op(r, w, a, d, r ? "R11 random read" : "R11 random hold");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule